// File: doc/BRIEF.md
# Per-channel digital silence detector

This block sits behind a serial audio receiver and watches the two decoded sample streams, left and right. For each channel it keeps a count of frame-clock periods since that channel last delivered a sample with any bit set. Once that count exceeds a fixed limit, 1024 frames by default, the channel's zero flag goes high. The flag is active high and stays low while signal is present.

Each channel has its own counter and its own flag, so silence on one side never affects the other. The receiver supplies a single-cycle frame strobe once per frame-clock period. It also supplies a single-cycle valid pulse per channel, qualifying that channel's sample word. The flags are plain level outputs that downstream logic may use as it sees fit.

Top module: `chan_silence_flags`

## Requirements
- R1: The left and right channels are tracked independently. A sample or silence on one channel never changes the other channel's flag or count.
- R2: A channel's flag goes high in the cycle after the clock edge that samples the (LIMIT+1)th frame strobe with no signal on that channel. After LIMIT strobes it is still low. LIMIT defaults to 1024.
- R3: The silence count saturates. During silence of any length beyond LIMIT, the flag stays high and never wraps back low.
- R4: A valid sample counts as signal when at least one bit of its word is 1. A word with only the least significant bit set counts as signal, and so does a word with only the most significant bit set.
- R5: A valid nonzero sample clears that channel's count, and the flag is low from the following cycle. When such a sample and a frame strobe arrive in the same cycle, the clear takes priority and counting restarts from zero.
- R6: A valid sample whose word is all zeros neither clears nor advances the count. Only frame strobes advance it.
- R7: While rst_n is low, both counts are zero and both flags are low. After release, counting starts from zero.
- R8: The sample word has no effect while its valid input is low, even when the word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse per frame-clock period |
| smp_valid_l | input | 1 | Left sample word is valid this cycle |
| smp_valid_r | input | 1 | Right sample word is valid this cycle |
| smp_data_l | input | SAMPLE_W | Left sample word |
| smp_data_r | input | SAMPLE_W | Right sample word |
| zero_l | output | 1 | Left channel silent for more than LIMIT frames |
| zero_r | output | 1 | Right channel silent for more than LIMIT frames |

## Verification
The assertions take the frame strobe and the valid pulses to be synchronous single-cycle events. They also take the sample words to be defined whenever the matching valid pulse is high. The stimulus changes inputs only on falling clock edges. It raises each strobe and valid for exactly one cycle and always drives known words, including nonzero words while valid is low. Strobes are spaced a few cycles apart, as a real frame clock would be. One case deliberately places a nonzero sample on the same cycle as a strobe.

// File: rtl/chan_silence_pkg.sv
package chan_silence_pkg;
  localparam int NUM_CH = 2;
  typedef enum int {CH_LEFT = 0, CH_RIGHT = 1} chan_e;
endpackage

// File: rtl/silence_tracker.sv
module silence_tracker #(
  parameter int SAMPLE_W = 24,
  parameter int LIMIT    = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_word,
  output logic                silent_flag,
  output logic                signal_seen
);
  localparam int SAT = LIMIT + 1;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_C = CW'(SAT);

  logic [CW-1:0] cnt_q;

  function automatic logic word_has_signal(input logic [SAMPLE_W-1:0] w);
    return |w;
  endfunction

  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] c);
    return (c == SAT_C) ? SAT_C : c + CW'(1);
  endfunction

  assign signal_seen = smp_valid & word_has_signal(smp_word);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (signal_seen) cnt_q <= '0;
    else if (frame_tick)  cnt_q <= sat_step(cnt_q);
  end

  assign silent_flag = (cnt_q == SAT_C);

  // R3: count never passes its ceiling
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_C);
  // R3: once set, flag holds while no signal arrives
  a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (silent_flag && !signal_seen) |=> silent_flag);
  // R5: a nonzero valid sample drops the flag on the next cycle
  a_r5_signal_clears: assert property (@(posedge clk) disable iff (!rst_n)
    signal_seen |=> !silent_flag);
  // R2: the flag only rises on a strobe
  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(silent_flag) |-> $past(frame_tick));
  // R6/R8: without a strobe or signal the count is unchanged
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !signal_seen) |=> $stable(cnt_q));
endmodule

// File: rtl/chan_silence_flags.sv
module chan_silence_flags
  import chan_silence_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int LIMIT    = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic                smp_valid_l,
  input  logic                smp_valid_r,
  input  logic [SAMPLE_W-1:0] smp_data_l,
  input  logic [SAMPLE_W-1:0] smp_data_r,
  output logic                zero_l,
  output logic                zero_r
);
  logic [NUM_CH-1:0]               valid_v;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] word_v;
  logic [NUM_CH-1:0]               flag_v;
  logic [NUM_CH-1:0]               seen_v;

  assign valid_v[CH_LEFT]  = smp_valid_l;
  assign valid_v[CH_RIGHT] = smp_valid_r;
  assign word_v[CH_LEFT]   = smp_data_l;
  assign word_v[CH_RIGHT]  = smp_data_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    silence_tracker #(.SAMPLE_W(SAMPLE_W), .LIMIT(LIMIT)) trk_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_tick (frame_tick),
      .smp_valid  (valid_v[c]),
      .smp_word   (word_v[c]),
      .silent_flag(flag_v[c]),
      .signal_seen(seen_v[c])
    );
  end

  assign zero_l = flag_v[CH_LEFT];
  assign zero_r = flag_v[CH_RIGHT];

  // R1: signal on the left alone leaves a high right flag high
  a_r1_right_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_v[CH_LEFT] && !seen_v[CH_RIGHT] && zero_r) |=> zero_r);
  // R1: signal on the right alone leaves a high left flag high
  a_r1_left_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_v[CH_RIGHT] && !seen_v[CH_LEFT] && zero_l) |=> zero_l);
endmodule

// File: tb/chan_silence_flags_tb.sv
module chan_silence_flags_tb_top;
  localparam int SW  = 24;
  localparam int LIM = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic vl = 1'b0, vr = 1'b0;
  logic [SW-1:0] dl = '0, dr = '0;
  logic zl, zr;

  int compared = 0, mismatched = 0, cycles = 0;
  int since_l = 0, since_r = 0;
  string phase = "R7";

  always #5 clk = ~clk;

  chan_silence_flags #(.SAMPLE_W(SW), .LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(tick),
    .smp_valid_l(vl), .smp_valid_r(vr), .smp_data_l(dl), .smp_data_r(dr),
    .zero_l(zl), .zero_r(zr));

  // behavioural reference: frames elapsed since last signal per channel
  always @(posedge clk) begin
    if (!rst_n) begin
      since_l = 0; since_r = 0;
    end else begin
      if (vl && dl != 0) since_l = 0; else if (tick) since_l = since_l + 1;
      if (vr && dr != 0) since_r = 0; else if (tick) since_r = since_r + 1;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    chk({phase, " left"},  zl, since_l > LIM);
    chk({phase, " right"}, zr, since_r > LIM);
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary_and_end();
    end
  end

  // one frame: strobe plus optional samples, then idle cycles
  task automatic frame(input logic t, input logic a_v, input logic [SW-1:0] a_d,
                       input logic b_v, input logic [SW-1:0] b_d);
    @(negedge clk);
    tick = t; vl = a_v; dl = a_d; vr = b_v; dr = b_d;
    @(negedge clk);
    tick = 0; vl = 0; vr = 0; dl = '0; dr = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic silent_frames(input int n);
    for (int i = 0; i < n; i++) frame(1'b1, 1'b1, '0, 1'b1, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset left", zl, 1'b0);
    chk("R7 reset right", zr, 1'b0);
    rst_n = 1'b1;

    phase = "R2";
    silent_frames(LIM);
    @(negedge clk);
    chk("R2 at limit left", zl, 1'b0);
    chk("R2 at limit right", zr, 1'b0);
    silent_frames(1);
    chk("R2 over limit left", zl, 1'b1);
    chk("R2 over limit right", zr, 1'b1);

    phase = "R3";
    silent_frames(2 * LIM + 40);
    chk("R3 long silence left", zl, 1'b1);
    chk("R3 long silence right", zr, 1'b1);

    phase = "R6";
    for (int i = 0; i < 5; i++) frame(1'b0, 1'b1, '0, 1'b1, '0);
    chk("R6 zero samples left", zl, 1'b1);

    phase = "R4";
    frame(1'b1, 1'b0, '0, 1'b1, SW'(1));
    chk("R4 lsb signal right", zr, 1'b0);
    chk("R1 left unaffected", zl, 1'b1);

    phase = "R8";
    frame(1'b1, 1'b0, {SW{1'b1}}, 1'b0, '0);
    chk("R8 unqualified word left", zl, 1'b1);

    phase = "R4";
    frame(1'b0, 1'b1, {1'b1, {(SW-1){1'b0}}}, 1'b0, '0);
    chk("R4 msb signal left", zl, 1'b0);

    phase = "R5";
    silent_frames(500);
    frame(1'b1, 1'b0, '0, 1'b1, SW'(24'h000100));
    silent_frames(LIM + 1 - 501);
    chk("R5 left over limit", zl, 1'b1);
    chk("R5 right restarted", zr, 1'b0);
    silent_frames(501);
    chk("R5 right over limit", zr, 1'b1);

    phase = "R1";
    frame(1'b1, 1'b1, SW'(24'h800001), 1'b0, '0);
    chk("R1 left cleared", zl, 1'b0);
    chk("R1 right held", zr, 1'b1);

    phase = "R7";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 mid-run left", zl, 1'b0);
    chk("R7 mid-run right", zr, 1'b0);
    rst_n = 1'b1;
    silent_frames(LIM);
    chk("R7 restart from zero", zr, 1'b0);
    silent_frames(1);
    chk("R7 restart over limit", zr, 1'b1);

    summary_and_end();
  end
endmodule